// File: doc/BRIEF.md
# Two-Wire Control Register Write Slave

This block is a serial slave for a two-wire bus with one clock line and one open-drain data line. It sits beside a clock fan-out stage and holds three 8-bit control bytes. Those bytes switch six differential output pairs on and off and choose a test mode. The block oversamples both bus lines with the system clock and finds START and STOP conditions. It accepts only write transfers aimed at its fixed 7-bit address.

A transfer has a fixed order. The address byte comes first, then a command byte that gives the first register index, then a count byte. Data bytes follow and go to consecutive registers until the count is used up. The slave pulls the data line low to acknowledge every byte it accepts. The enable vector for the six pairs and the test-mode flag are decoded from the stored bytes and registered. The feedback clock path has no enable and is not controlled here.

Top module: `ctl_twowire_slave`

## Requirements
- R1: After reset the bytes read reg0_o = 0xFF, reg1_o = 0xC0 and reg2_o = 0xC0. pair_en_o reads 0x3F, leak_test_o is 0 and sda_pull_o is 0.
- R2: A first byte after START carries the address in bits 7..1 and the direction in bit 0. If the address equals SLAVE_ADDR and bit 0 is 0, the slave asserts sda_pull_o for the whole 9th SCL clock.
- R3: If the address differs, or bit 0 is 1, the slave does not acknowledge. It also neither acknowledges nor writes any later byte until the next START.
- R4: After an acknowledged address, the next byte is the command (start index) and the byte after it is the count. Both are acknowledged. Data bytes then write register index, index+1 and so on, and each data byte is acknowledged.
- R5: pair_en_o bit p is 1 when pair p is enabled. Pair 0 follows reg0 bit 7, pair 1 reg0 bit 6, pair 2 reg0 bit 3, pair 3 reg1 bit 6, pair 4 reg0 bit 0 and pair 5 reg0 bit 2.
- R6: leak_test_o is the inverse of reg2 bit 7, so 0 in that bit selects the leakage test.
- R7: Once as many data bytes as the count byte gives have been written, further bytes are neither acknowledged nor written.
- R8: A STOP ends the transfer at once. Bytes already written are kept, and the slave returns to idle.
- R9: Reserved bit positions are stored and read back on the reg outputs, but they do not change pair_en_o.
- R10: A START in the middle of a transfer abandons it and starts address reception again.
- R11: sda_pull_o changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| reg0_o | output | 8 | Control byte 0 |
| reg1_o | output | 8 | Control byte 1 |
| reg2_o | output | 8 | Control byte 2 (test byte) |
| pair_en_o | output | 6 | Enable per differential output pair |
| leak_test_o | output | 1 | 1 while the leakage test is selected |

## Verification
On every cycle the assertions check four things: the pair decode and test-flag mapping against the stored bytes, that a register changes only after a write strobe for its index, that the data line moves only while SCL is low, and that the slave is idle after a STOP. The following need whole bus scenarios driven by the bench: address and direction filtering, the command-then-count ordering, the count limit, an early STOP, a repeated START, and reserved bits being stored without effect.

// File: rtl/ctl_twowire_pkg.sv
package ctl_twowire_pkg;
  localparam int NUM_REGS  = 3;
  localparam int NUM_PAIRS = 6;
  localparam int BYTE_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA, ST_SKIP
  } bus_state_t;

  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    return (idx == 0) ? 8'hFF : 8'hC0;
  endfunction

  function automatic logic [NUM_PAIRS-1:0] pair_decode(
    input logic [BYTE_W-1:0] b0, input logic [BYTE_W-1:0] b1);
    logic [NUM_PAIRS-1:0] v;
    v[0] = b0[7];
    v[1] = b0[6];
    v[2] = b0[3];
    v[3] = b1[6];
    v[4] = b0[0];
    v[5] = b0[2];
    return v;
  endfunction
endpackage

// File: rtl/ctl_twowire_sync.sv
module ctl_twowire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ctl_twowire_fsm.sv
module ctl_twowire_fsm
  import ctl_twowire_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output bus_state_t        state_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  bus_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, ptr, remain;

  always_ff @(posedge clk) begin
    wr_en_o <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      remain    <= '0;
      ack_o     <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      ack_o  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      ack_o  <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise && bitcnt < LAST_BIT) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall && bitcnt == LAST_BIT) begin
        bitcnt <= ACK_BIT;
        case (state)
          ST_ADDR: begin
            if (shreg[7:1] == SLAVE_ADDR && !shreg[0]) begin
              ack_o <= 1'b1;
              state <= ST_CMD;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_CMD: begin
            ptr   <= shreg;
            ack_o <= 1'b1;
            state <= ST_CNT;
          end
          ST_CNT: begin
            remain <= shreg;
            ack_o  <= 1'b1;
            state  <= (shreg == '0) ? ST_SKIP : ST_DATA;
          end
          ST_DATA: begin
            wr_en_o   <= 1'b1;
            wr_idx_o  <= ptr;
            wr_data_o <= shreg;
            ptr       <= ptr + 1'b1;
            remain    <= remain - 1'b1;
            ack_o     <= 1'b1;
            if (remain == 8'd1) state <= ST_SKIP;
          end
          default: ack_o <= 1'b0;
        endcase
      end else if (scl_fall && bitcnt == ACK_BIT) begin
        bitcnt <= '0;
        ack_o  <= 1'b0;
      end
    end
  end

  assign state_o = state;
endmodule

// File: rtl/ctl_twowire_regs.sv
module ctl_twowire_regs
  import ctl_twowire_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [BYTE_W-1:0]                wr_idx,
  input  logic [BYTE_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs_o,
  output logic [NUM_PAIRS-1:0]             pair_en_o,
  output logic                             leak_test_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_o[i] <= reg_default(i);
      else if (wr_en && wr_idx == BYTE_W'(i))
        regs_o[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_en_o   <= pair_decode(reg_default(0), reg_default(1));
      leak_test_o <= ~reg_default(2)[7];
    end else begin
      pair_en_o   <= pair_decode(regs_o[0], regs_o[1]);
      leak_test_o <= ~regs_o[2][7];
    end
  end
endmodule

// File: rtl/ctl_twowire_slave.sv
module ctl_twowire_slave
  import ctl_twowire_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] reg0_o,
  output logic [7:0] reg1_o,
  output logic [7:0] reg2_o,
  output logic [5:0] pair_en_o,
  output logic       leak_test_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [BYTE_W-1:0] wr_idx, wr_data;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
  bus_state_t state;

  ctl_twowire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  ctl_twowire_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_o(sda_pull_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .state_o(state));

  ctl_twowire_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_o(regs), .pair_en_o(pair_en_o), .leak_test_o(leak_test_o));

  assign reg0_o = regs[0];
  assign reg1_o = regs[1];
  assign reg2_o = regs[2];
endmodule

// File: rtl/ctl_twowire_slave_chk.sv
module ctl_twowire_slave_chk
  import ctl_twowire_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_pull,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_idx,
  input logic [7:0]        reg0,
  input logic [7:0]        reg1,
  input logic [7:0]        reg2,
  input logic [5:0]        pair_en,
  input logic              leak,
  input logic              stop_det,
  input bus_state_t        state
);
  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg0 == 8'hFF && reg1 == 8'hC0 && reg2 == 8'hC0 && !sda_pull));

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg0) |-> $past(wr_en && wr_idx == 8'd0));

  p_pair_map_r5: assert property (@(posedge clk) disable iff (rst)
    pair_en == {$past(reg0[2]), $past(reg0[0]), $past(reg1[6]),
                $past(reg0[3]), $past(reg0[6]), $past(reg0[7])});

  p_test_flag_r6: assert property (@(posedge clk) disable iff (rst)
    leak == !$past(reg2[7]));

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_pull));

  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !$past(scl_s));
endmodule

bind ctl_twowire_slave ctl_twowire_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull_o), .wr_en(wr_en),
  .wr_idx(wr_idx), .reg0(reg0_o), .reg1(reg1_o), .reg2(reg2_o),
  .pair_en(pair_en_o), .leak(leak_test_o), .stop_det(stop_det), .state(state));

// File: tb/test_ctl_twowire_slave.sv
`timescale 1ns/1ps
module test_ctl_twowire_slave;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_o, leak_test_o;
  logic [7:0] reg0_o, reg1_o, reg2_o;
  logic [5:0] pair_en_o;
  logic sda_w;
  logic ack_slot = 1'b0;
  int tests = 0;
  int fails = 0;
  bit exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  assign sda_w = sda_m & ~sda_pull_o;

  ctl_twowire_slave #(.SLAVE_ADDR(ADDR)) i_ctl_twowire_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_w),
    .sda_pull_o(sda_pull_o), .reg0_o(reg0_o), .reg1_o(reg1_o),
    .reg2_o(reg2_o), .pair_en_o(pair_en_o), .leak_test_o(leak_test_o));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  // driver: shifts a byte out and queues the expected acknowledge
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    exp_q.push_back(exp_ack);
    tag_q.push_back(req);
    ack_slot = 1'b1;
    bus_bit(1'b1);
    ack_slot = 1'b0;
  endtask

  // monitor: compares the acknowledge seen on the line with the queue
  initial begin
    forever begin
      @(posedge scl_m);
      if (ack_slot) begin
        bit e;
        string t;
        #3;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {7'd0, sda_pull_o}, {7'd0, e});
      end
    end
  end

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] e2, input logic [5:0] ep, input logic el);
    settle();
    check({req, " reg0"}, reg0_o, e0);
    check({req, " reg1"}, reg1_o, e1);
    check({req, " reg2"}, reg2_o, e2);
    check({req, " pair_en"}, {2'b0, pair_en_o}, {2'b0, ep});
    check({req, " leak"}, {7'd0, leak_test_o}, {7'd0, el});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    check("R1 pull", {7'd0, sda_pull_o}, 8'd0);
    check_all("R1", 8'hFF, 8'hC0, 8'hC0, 6'h3F, 1'b0);

    // R2 R4 R6: full three-byte write starting at index 0
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 addr ack");
    send_byte(8'h00, 1, "R4 cmd ack");
    send_byte(8'h03, 1, "R4 count ack");
    send_byte(8'h00, 1, "R4 data0 ack");
    send_byte(8'h00, 1, "R4 data1 ack");
    send_byte(8'h40, 1, "R4 data2 ack");
    bus_stop();
    check_all("R4_R6", 8'h00, 8'h00, 8'h40, 6'h00, 1'b1);

    // R3 wrong address
    bus_start();
    send_byte({7'h12, 1'b0}, 0, "R3 wrong addr nak");
    send_byte(8'h00, 0, "R3 cmd nak");
    send_byte(8'h01, 0, "R3 count nak");
    send_byte(8'hFF, 0, "R3 data nak");
    bus_stop();
    check_all("R3 wrong addr", 8'h00, 8'h00, 8'h40, 6'h00, 1'b1);

    // R3 read direction
    bus_start();
    send_byte({ADDR, 1'b1}, 0, "R3 read nak");
    send_byte(8'hFF, 0, "R3 after read nak");
    bus_stop();
    check_all("R3 read", 8'h00, 8'h00, 8'h40, 6'h00, 1'b1);

    // R7 count limit at index 1
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R7 addr");
    send_byte(8'h01, 1, "R7 cmd");
    send_byte(8'h01, 1, "R7 count");
    send_byte(8'h40, 1, "R7 data");
    send_byte(8'h55, 0, "R7 extra nak");
    bus_stop();
    check_all("R7", 8'h00, 8'h40, 8'h40, 6'h08, 1'b1);

    // R8 early stop
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R8 addr");
    send_byte(8'h00, 1, "R8 cmd");
    send_byte(8'h03, 1, "R8 count");
    send_byte(8'h80, 1, "R8 data");
    bus_stop();
    check_all("R8", 8'h80, 8'h40, 8'h40, 6'h09, 1'b1);

    // R9 reserved bits stored without effect
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R9 addr");
    send_byte(8'h00, 1, "R9 cmd");
    send_byte(8'h02, 1, "R9 count");
    send_byte(8'h32, 1, "R9 data0");
    send_byte(8'hBF, 1, "R9 data1");
    bus_stop();
    check_all("R9", 8'h32, 8'hBF, 8'h40, 6'h00, 1'b1);

    // R10 repeated start mid-transfer
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R10 addr");
    send_byte(8'h00, 1, "R10 cmd");
    send_byte(8'h02, 1, "R10 count");
    send_byte(8'hFF, 1, "R10 data");
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R10 re-addr");
    send_byte(8'h02, 1, "R10 cmd2");
    send_byte(8'h01, 1, "R10 count2");
    send_byte(8'h80, 1, "R10 data2");
    bus_stop();
    check_all("R10", 8'hFF, 8'hBF, 8'h80, 6'h37, 1'b0);

    // R5 pairs 4 and 5 from reg0 bits 0 and 2
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R5 addr");
    send_byte(8'h00, 1, "R5 cmd");
    send_byte(8'h01, 1, "R5 count");
    send_byte(8'h05, 1, "R5 data");
    bus_stop();
    check_all("R5", 8'h05, 8'hBF, 8'h80, 6'h30, 1'b0);
    check("R11 idle pull", {7'd0, sda_pull_o}, 8'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule